// File: doc/BRIEF.md
# I/O Address Trap Monitor

The block watches processor I/O cycles and compares each observed address against four programmable trap windows. A window is defined by a 16-bit base address and a 4-bit mask. Each set mask bit removes one of the four lowest address bits from the comparison, so a window covers 1, 2, 4, 8 or 16 consecutive ports, or a scattered pattern of them within one 16-port block. When an enabled window is hit, the block sets a sticky per-monitor status bit. It keeps a system-management interrupt request asserted for as long as any status bit is set.

On each observed cycle the block also reports a forwarding decision to the downstream decoder. A cycle aimed at an internal register always proceeds to its target. A cycle aimed at the low-pin-count legacy bus proceeds only if every enabled monitor it hit allows forwarding. Configuration and status are reached through a small word-wide register port with a 3-bit index. Bus protocol decoding, the target devices themselves and the interrupt controller sit outside this block.

Top module: `io_trap_monitor`

## Requirements
- R1: After reset, all eight registers read 0, `smi_req` is 0 and `fwd_valid` and `fwd_ok` are 0.
- R2: The register index selects the register as follows:
  - 0 to 3: the base of monitor 0 to 3.
  - 4: the mask register, with monitor n's nibble at bits 4n+3:4n.
  - 5: trap enable, with monitor n at bit n.
  - 6: forward enable, with monitor n at bit n.
  - 7: status, with monitor n at bit n.
- R3: `reg_rdata` shows the current value of the register that `reg_idx` selects. Bits above bit 3 of registers 5, 6 and 7 read 0. A write with `reg_we` high takes effect on the next rising clock, and is not visible before it.
- R4: A monitor matches when address bits 15:4 equal its base, and each address bit i (i = 0 to 3) equals base bit i or has mask bit i set. With base 1230h and mask 0011b, the addresses 1230h to 1233h match and 1234h does not.
- R5: On the rising clock that samples `cyc_valid` high, the status bit of every monitor that matches and has its trap-enable bit set becomes 1. The status bit of a matching monitor whose trap-enable bit is clear is not set.
- R6: `smi_req` is 1 exactly when at least one status bit is 1.
- R7: Writing register 7 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged. If a new hit arrives on the same clock as the clear, the hit wins for that bit.
- R8: If several enabled monitors match one cycle, all of their status bits are set.
- R9: `fwd_valid` is 1 for one clock after each clock that samples `cyc_valid` high. While it is 1:
  - `fwd_ok` is 1 when `cyc_to_lpc` was 0.
  - `fwd_ok` is 1 when `cyc_to_lpc` was 1 and every enabled matching monitor has its forward-enable bit set.
  - `fwd_ok` is 0 otherwise.
  - `fwd_ok` is 0 whenever `fwd_valid` is 0.
- R10: While `cyc_valid` is 0, the address has no effect: no status bit is set and `fwd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_idx` |
| cyc_valid | input | 1 | An I/O cycle is presented this clock |
| cyc_addr | input | 16 | I/O address of the cycle |
| cyc_to_lpc | input | 1 | Cycle targets the legacy bus (1) or an internal register (0) |
| smi_req | output | 1 | System-management interrupt request |
| fwd_valid | output | 1 | Forwarding decision valid |
| fwd_ok | output | 1 | Cycle may proceed to its target |

## Verification
The bench probes the edges of the masked windows:
- the last matching address and the first non-matching address of each window (1233h against 1234h);
- a full-nibble mask against the neighbouring block just below it;
- two overlapping windows that match the same address.

A wrong mask polarity or a mask applied above bit 3 would wrongly accept or reject exactly these addresses. The bench checks a matching but disabled monitor, which a design that ignored the trap enable would report as a hit. It also checks a mixed case where one hitting monitor allows forwarding and another does not, which a design that ORs the forward enables would wrongly let through. It drives a status clear on the same clock as a new hit, and a write is read back before its clock edge to catch an early or combinational write path.

// File: rtl/iotm_pkg.sv
package iotm_pkg;
    localparam int ADDR_W = 16;
    localparam int NUM_MON = 4;
    localparam int MASK_W = 4;
    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_MASK    = 3'd4;
    localparam logic [IDX_W-1:0] IDX_TRAP_EN = 3'd5;
    localparam logic [IDX_W-1:0] IDX_FWD_EN  = 3'd6;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd7;
endpackage

// File: rtl/iotm_window.sv
module iotm_window #(
    parameter int ADDR_W = iotm_pkg::ADDR_W,
    parameter int MASK_W = iotm_pkg::MASK_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    localparam int HIGH_W = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] care;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        care = {{HIGH_W{1'b1}}, ~mask};
        diff = (addr ^ base) & care;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/iotm_regs.sv
module iotm_regs #(
    parameter int ADDR_W  = iotm_pkg::ADDR_W,
    parameter int NUM_MON = iotm_pkg::NUM_MON,
    parameter int MASK_W  = iotm_pkg::MASK_W,
    parameter int IDX_W   = iotm_pkg::IDX_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               idx,
    input  logic [ADDR_W-1:0]              wdata,
    output logic [NUM_MON-1:0][ADDR_W-1:0] base,
    output logic [NUM_MON-1:0][MASK_W-1:0] mask,
    output logic [NUM_MON-1:0]             trap_en,
    output logic [NUM_MON-1:0]             fwd_en,
    output logic [ADDR_W-1:0]              rdata
);
    import iotm_pkg::*;

    localparam int SEL_W = (NUM_MON > 1) ? $clog2(NUM_MON) : 1;
    localparam int PACK_W = NUM_MON * MASK_W;
    localparam logic [IDX_W-1:0] BASE_LIMIT = IDX_W'(NUM_MON);

    typedef struct packed {
        logic [NUM_MON-1:0][ADDR_W-1:0] base;
        logic [NUM_MON-1:0][MASK_W-1:0] mask;
        logic [NUM_MON-1:0]             trap_en;
        logic [NUM_MON-1:0]             fwd_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel   = idx[SEL_W-1:0];
        cfg_d = cfg_q;
        if (we) begin
            if (idx < BASE_LIMIT) begin
                cfg_d.base[sel] = wdata;
            end else begin
                case (idx)
                    IDX_MASK:    cfg_d.mask    = wdata[PACK_W-1:0];
                    IDX_TRAP_EN: cfg_d.trap_en = wdata[NUM_MON-1:0];
                    IDX_FWD_EN:  cfg_d.fwd_en  = wdata[NUM_MON-1:0];
                    default:     cfg_d = cfg_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (idx < BASE_LIMIT) begin
            rdata = cfg_q.base[sel];
        end else begin
            case (idx)
                IDX_MASK:    rdata[PACK_W-1:0]  = cfg_q.mask;
                IDX_TRAP_EN: rdata[NUM_MON-1:0] = cfg_q.trap_en;
                IDX_FWD_EN:  rdata[NUM_MON-1:0] = cfg_q.fwd_en;
                default:     rdata = '0;
            endcase
        end
    end

    assign base    = cfg_q.base;
    assign mask    = cfg_q.mask;
    assign trap_en = cfg_q.trap_en;
    assign fwd_en  = cfg_q.fwd_en;
endmodule

// File: rtl/io_trap_monitor.sv
module io_trap_monitor #(
    parameter int ADDR_W  = iotm_pkg::ADDR_W,
    parameter int NUM_MON = iotm_pkg::NUM_MON,
    parameter int MASK_W  = iotm_pkg::MASK_W,
    parameter int IDX_W   = iotm_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_to_lpc,
    output logic              smi_req,
    output logic              fwd_valid,
    output logic              fwd_ok
);
    import iotm_pkg::*;

    typedef struct packed {
        logic [NUM_MON-1:0] status;
        logic               fwd_valid;
        logic               fwd_ok;
    } state_t;

    logic [NUM_MON-1:0][ADDR_W-1:0] base;
    logic [NUM_MON-1:0][MASK_W-1:0] mask;
    logic [NUM_MON-1:0]             trap_en;
    logic [NUM_MON-1:0]             fwd_en;
    logic [ADDR_W-1:0]              cfg_rdata;
    logic [NUM_MON-1:0]             match;
    logic [NUM_MON-1:0]             hit_en;
    logic                           lpc_blocked;
    logic                           status_wr;

    state_t st_d, st_q;

    iotm_regs #(
        .ADDR_W (ADDR_W),
        .NUM_MON(NUM_MON),
        .MASK_W (MASK_W),
        .IDX_W  (IDX_W)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .idx    (reg_idx),
        .wdata  (reg_wdata),
        .base   (base),
        .mask   (mask),
        .trap_en(trap_en),
        .fwd_en (fwd_en),
        .rdata  (cfg_rdata)
    );

    for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
        iotm_window #(
            .ADDR_W(ADDR_W),
            .MASK_W(MASK_W)
        ) win_i (
            .addr(cyc_addr),
            .base(base[m]),
            .mask(mask[m]),
            .hit (match[m])
        );
    end

    always_comb begin
        hit_en      = match & trap_en;
        lpc_blocked = cyc_to_lpc && ((hit_en & ~fwd_en) != '0);
        status_wr   = reg_we && (reg_idx == IDX_STATUS);

        st_d = st_q;
        if (status_wr) begin
            st_d.status = st_q.status & ~reg_wdata[NUM_MON-1:0];
        end
        if (cyc_valid) begin
            st_d.status = st_d.status | hit_en;
        end
        st_d.fwd_valid = cyc_valid;
        st_d.fwd_ok    = cyc_valid && !lpc_blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (reg_idx == IDX_STATUS) begin
            reg_rdata = {{(ADDR_W-NUM_MON){1'b0}}, st_q.status};
        end else begin
            reg_rdata = cfg_rdata;
        end
    end

    assign smi_req   = |st_q.status;
    assign fwd_valid = st_q.fwd_valid;
    assign fwd_ok    = st_q.fwd_ok;
endmodule

// File: rtl/iotm_checker.sv
module iotm_checker #(
    parameter int ADDR_W = iotm_pkg::ADDR_W,
    parameter int IDX_W  = iotm_pkg::IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic              cyc_valid,
    input logic              cyc_to_lpc,
    input logic              smi_req,
    input logic              fwd_valid,
    input logic              fwd_ok
);
    AST_FWD_FOLLOWS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> fwd_valid); // R9
    AST_NO_CYCLE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> !fwd_valid); // R10
    AST_INTERNAL_PROCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_to_lpc) |=> fwd_ok); // R9
    AST_OK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_ok |-> fwd_valid); // R9
    AST_SMI_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> $past(cyc_valid)); // R5
    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == 3'd7 && reg_wdata[3:0] == 4'hF && !cyc_valid) |=> !smi_req); // R7
endmodule

bind io_trap_monitor iotm_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .cyc_valid (cyc_valid),
    .cyc_to_lpc(cyc_to_lpc),
    .smi_req   (smi_req),
    .fwd_valid (fwd_valid),
    .fwd_ok    (fwd_ok)
);

// File: tb/io_trap_monitor_tb_top.sv
module io_trap_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        cyc_valid = 1'b0;
    logic [15:0] cyc_addr = 16'h0;
    logic        cyc_to_lpc = 1'b0;
    logic        smi_req, fwd_valid, fwd_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    io_trap_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid),
        .cyc_addr(cyc_addr), .cyc_to_lpc(cyc_to_lpc), .smi_req(smi_req),
        .fwd_valid(fwd_valid), .fwd_ok(fwd_ok)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic        lpc;
        logic [3:0]  status;
        logic        ok;
    } vec_t;

    // Windows: m0 1230h/0011b, m1 1230h/0000b, m2 80F0h/1111b, m3 0070h/0001b
    // forward enable: m0 and m2 only
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{16'h1230, 1'b1, 4'b0011, 1'b0},
        '{16'h1233, 1'b1, 4'b0001, 1'b1},
        '{16'h1234, 1'b1, 4'b0000, 1'b1},
        '{16'h1231, 1'b0, 4'b0001, 1'b1},
        '{16'h80FF, 1'b1, 4'b0100, 1'b1},
        '{16'h80EF, 1'b1, 4'b0000, 1'b1},
        '{16'h80F7, 1'b0, 4'b0100, 1'b1},
        '{16'h0071, 1'b1, 4'b1000, 1'b0},
        '{16'h0072, 1'b1, 4'b0000, 1'b1},
        '{16'h1230, 1'b0, 4'b0011, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] data);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [15:0] data);
        reg_idx = idx;
        #1;
        data = reg_rdata;
    endtask

    task automatic cyc(input logic [15:0] addr, input logic lpc);
        cyc_valid = 1'b1; cyc_addr = addr; cyc_to_lpc = lpc;
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R1 reg after reset", v, 16'h0);
        end
        chk("R1 smi after reset", {15'h0, smi_req}, 16'h0);
        chk("R1 fwd_valid after reset", {15'h0, fwd_valid}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 write not visible before the clock edge, visible after
        reg_we = 1'b1; reg_idx = 3'd0; reg_wdata = 16'h5550;
        #1;
        chk("R3 write visible early", reg_rdata, 16'h0000);
        @(negedge clk);
        reg_we = 1'b0;
        rd(3'd0, v);
        chk("R3 write after edge", v, 16'h5550);

        // R2 map, R3 unused bits read zero
        wr(3'd0, 16'h1230);
        wr(3'd1, 16'h1230);
        wr(3'd2, 16'h80F0);
        wr(3'd3, 16'h0070);
        wr(3'd4, 16'h1F03);
        wr(3'd5, 16'hFFFF);
        wr(3'd6, 16'hFFF5);
        rd(3'd2, v); chk("R2 base2", v, 16'h80F0);
        rd(3'd3, v); chk("R2 base3", v, 16'h0070);
        rd(3'd4, v); chk("R2 mask", v, 16'h1F03);
        rd(3'd5, v); chk("R3 trap_en upper zero", v, 16'h000F);
        rd(3'd6, v); chk("R3 fwd_en upper zero", v, 16'h0005);

        // Vector table: R4 R5 R6 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            cyc(VECS[i].addr, VECS[i].lpc);
            chk($sformatf("R9 fwd_valid vec %0d", i), {15'h0, fwd_valid}, 16'h1);
            chk($sformatf("R9 fwd_ok vec %0d", i), {15'h0, fwd_ok}, {15'h0, VECS[i].ok});
            rd(3'd7, v);
            chk($sformatf("R4 R5 R8 status vec %0d", i), v, {12'h0, VECS[i].status});
            chk($sformatf("R6 smi vec %0d", i), {15'h0, smi_req}, {15'h0, (VECS[i].status != 4'h0)});
            wr(3'd7, 16'h000F);
            chk($sformatf("R9 fwd idle vec %0d", i), {14'h0, fwd_valid, fwd_ok}, 16'h0);
        end

        // R5 disabled monitor is not reported
        wr(3'd5, 16'h000E);
        cyc(16'h1233, 1'b1);
        rd(3'd7, v);
        chk("R5 disabled monitor status", v, 16'h0);
        chk("R5 disabled monitor smi", {15'h0, smi_req}, 16'h0);
        chk("R9 disabled monitor no block", {15'h0, fwd_ok}, 16'h1);
        wr(3'd5, 16'h000F);

        // R10 address without cycle_valid is ignored
        cyc_addr = 16'h1230; cyc_to_lpc = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd7, v);
        chk("R10 no cycle status", v, 16'h0);
        chk("R10 no cycle fwd_valid", {15'h0, fwd_valid}, 16'h0);

        // R7 partial clear
        cyc(16'h1230, 1'b1);
        wr(3'd7, 16'h0001);
        rd(3'd7, v);
        chk("R7 partial clear", v, 16'h0002);
        chk("R6 smi still set", {15'h0, smi_req}, 16'h1);

        // R7 clear and hit on the same clock
        reg_we = 1'b1; reg_idx = 3'd7; reg_wdata = 16'h000F;
        cyc_valid = 1'b1; cyc_addr = 16'h1233; cyc_to_lpc = 1'b0;
        @(negedge clk);
        reg_we = 1'b0; cyc_valid = 1'b0;
        rd(3'd7, v);
        chk("R7 hit wins over clear", v, 16'h0001);

        // R1 reset in the middle of operation
        rst_n = 1'b0;
        #1;
        rd(3'd7, v); chk("R1 status after reset", v, 16'h0);
        rd(3'd4, v); chk("R1 mask after reset", v, 16'h0);
        chk("R1 smi after reset mid", {15'h0, smi_req}, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule